// File: doc/BRIEF.md
# Programmable-Width Byte Pointer Access Unit

This unit gives a word-addressed memory byte access where the byte width is not fixed. Each command carries a pointer descriptor with three fields: a word address, a byte width in bits, and a bit offset that counts how many bits of the word lie to the right of the byte. A load command fetches the addressed word, shifts the selected field down to bit 0 and clears every other bit. A deposit command fetches the target word, clears the field, merges in the low bits of the supplied data and writes the word back to the same address.

Either command can first step the pointer to the next byte. Stepping lowers the offset by the width. When that would go below zero, the pointer moves to the next word address and the offset becomes the word width minus the byte width. The stepped pointer is then the one used for the access, and it is returned to the caller. The unit connects to a synchronous single-port memory with one cycle of read latency. A caller pulses a start strobe and then waits for a one-cycle done pulse.

Top module: `bptr_unit`

## Requirements
- R1: After a synchronous active-low reset, busy_o, done_o, mem_rd_o and mem_wr_o are low. The pointer layout is: ptr_i[17:0] is the word address, ptr_i[23:18] is the byte width and ptr_i[29:24] is the bit offset.
- R2: A load with op_deposit_i=0 returns, in the cycle done_o is high, load_o equal to word bits [offset+width-1:offset] placed at bit 0, with all upper bits zero.
- R3: A load with byte width zero returns a load_o of zero.
- R4: A deposit (op_deposit_i=1) issues one read and then, in the very next cycle, one write to the same address. No other access comes between them, and mem_rd_o and mem_wr_o are never high together.
- R5: A deposit replaces only the field bits of the word with the low bits of data_i. Every other bit keeps its value. A width of zero leaves the word unchanged.
- R6: With step_i=1 and offset >= width, the new offset is the offset minus the width and the word address does not change.
- R7: With step_i=1 and offset < width, the word address goes up by one and the offset becomes 36 minus the width. The access uses this new pointer.
- R8: With step_i=0 the pointer is not changed: ptr_o equals ptr_i.
- R9: When offset+width is greater than 36, only the field bits that lie inside the word are loaded or replaced.
- R10: A start that arrives while busy_o is high is ignored. Such a start produces no extra access and no extra done pulse, and ptr_o stays stable while busy.
- R11: busy_o goes high in the cycle after an accepted start. done_o is high for exactly one cycle, in the third cycle after the start edge. ptr_o and load_o are valid while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command strobe, accepted only when idle |
| op_deposit_i | input | 1 | 1 = deposit, 0 = load |
| step_i | input | 1 | Step the pointer before the access |
| ptr_i | input | 30 | Pointer: offset[29:24], width[23:18], address[17:0] |
| data_i | input | 36 | Source data for a deposit |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ptr_o | output | 30 | Pointer used for the access, after any step |
| load_o | output | 36 | Zero-extended loaded byte |
| mem_addr_o | output | 18 | Memory word address |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_wdata_o | output | 36 | Memory write data |
| mem_rdata_i | input | 36 | Memory read data, one cycle after mem_rd_o |

## Verification
A wrong step computation appears on ptr_o at the very next done pulse, three cycles after start. It also appears on the memory address bus one cycle after the start edge, so in a chain of stepped accesses it shows up on the first word crossing. A bad field mask either corrupts bits next to the field in memory, which is visible as soon as the write lands and is checked at done, or lets stray bits into load_o. A controller that slips into a wrong state shows either a write that does not follow its read, or a done pulse that is missing or doubled. The first case is flagged in the cycle of the write. The second is flagged when the scoreboard queue and the done count disagree.

// File: rtl/bptr_pkg.sv
// Package bptr_pkg
// Purpose: shared size defaults and the controller state type for the
//          byte pointer unit.
// Assumes: none.
package bptr_pkg;
    localparam int WORD_W_DEF = 36;
    localparam int SZ_W_DEF   = 6;
    localparam int POS_W_DEF  = 6;
    localparam int ADDR_W_DEF = 18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_XF   = 2'd2,
        ST_DN   = 2'd3
    } bptr_state_t;
endpackage

// File: rtl/bptr_advance.sv
// Module bptr_advance
// Purpose: steps a pointer to the next byte. The offset goes down by the
//          width; on underflow the address goes up by one and the offset
//          reloads to WORD_W - width.
// Assumes: pointer layout {offset, width, address}, with the address in the
//          low bits.
module bptr_advance #(
    parameter int WORD_W = bptr_pkg::WORD_W_DEF,
    parameter int SZ_W   = bptr_pkg::SZ_W_DEF,
    parameter int POS_W  = bptr_pkg::POS_W_DEF,
    parameter int ADDR_W = bptr_pkg::ADDR_W_DEF,
    localparam int PTR_W = POS_W + SZ_W + ADDR_W
) (
    input  logic             en_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam int CMP_W = ((POS_W > SZ_W) ? POS_W : SZ_W) + 1;

    logic [POS_W-1:0]  cur_pos;
    logic [SZ_W-1:0]   cur_size;
    logic [ADDR_W-1:0] cur_addr;
    logic [POS_W-1:0]  nxt_pos;
    logic [ADDR_W-1:0] nxt_addr;

    assign cur_addr = ptr_i[ADDR_W-1:0];
    assign cur_size = ptr_i[ADDR_W +: SZ_W];
    assign cur_pos  = ptr_i[ADDR_W+SZ_W +: POS_W];

    // Pick the stepped offset and address, or pass the pointer through
    always_comb begin
        nxt_pos  = cur_pos;
        nxt_addr = cur_addr;
        if (en_i) begin
            if (CMP_W'(cur_pos) >= CMP_W'(cur_size)) begin
                nxt_pos = cur_pos - POS_W'(cur_size);
            end else begin
                nxt_addr = cur_addr + ADDR_W'(1);
                nxt_pos  = POS_W'(WORD_W) - POS_W'(cur_size);
            end
        end
    end

    assign ptr_o = {nxt_pos, cur_size, nxt_addr};
endmodule

// File: rtl/bptr_field.sv
// Module bptr_field
// Purpose: builds the field mask from offset and width, extracts the field
//          of a word zero-extended, and merges new data into the field.
// Assumes: field bits that fall above the word are dropped.
module bptr_field #(
    parameter int WORD_W = bptr_pkg::WORD_W_DEF,
    parameter int SZ_W   = bptr_pkg::SZ_W_DEF,
    parameter int POS_W  = bptr_pkg::POS_W_DEF
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [SZ_W-1:0]   size_i,
    output logic [WORD_W-1:0] extract_o,
    output logic [WORD_W-1:0] merge_o
);
    localparam int SUM_W = ((POS_W > SZ_W) ? POS_W : SZ_W) + 8;

    logic [SUM_W-1:0]  lo_bit;
    logic [SUM_W-1:0]  hi_bit;
    logic [WORD_W-1:0] field_mask;
    logic [WORD_W-1:0] insert_bits;

    assign lo_bit = SUM_W'(pos_i);
    assign hi_bit = SUM_W'(pos_i) + SUM_W'(size_i);

    // Each word bit belongs to the field when lo <= bit < lo + width
    for (genvar b = 0; b < WORD_W; b++) begin : g_mask
        assign field_mask[b] = (SUM_W'(b) >= lo_bit) && (SUM_W'(b) < hi_bit);
    end

    // Align down for load; align up and merge for deposit
    always_comb begin
        extract_o   = (word_i & field_mask) >> pos_i;
        insert_bits = (data_i << pos_i) & field_mask;
        merge_o     = (word_i & ~field_mask) | insert_bits;
    end
endmodule

// File: rtl/bptr_ctrl.sv
// Module bptr_ctrl
// Purpose: sequences one command: read, then transfer (and write for a
//          deposit), then done.
// Assumes: memory read data is valid one cycle after the read request.
module bptr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic dep_i,
    output logic accept_o,
    output logic xfer_o,
    output logic busy_o,
    output logic done_o,
    output logic rd_o,
    output logic wr_o
);
    import bptr_pkg::*;

    bptr_state_t state_q;
    bptr_state_t state_d;

    // Next-state choice for the four-phase sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RD;
            ST_RD:   state_d = ST_XF;
            ST_XF:   state_d = ST_DN;
            ST_DN:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign accept_o = start_i && (state_q == ST_IDLE);
    assign xfer_o   = (state_q == ST_XF);
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_DN);
    assign rd_o     = (state_q == ST_RD);
    assign wr_o     = (state_q == ST_XF) && dep_i;

    assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o));
    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> $past(rd_o));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/bptr_unit.sv
// Module bptr_unit
// Purpose: top of the byte pointer load/deposit unit. Steps the pointer
//          if asked, reads the word, and either returns the field or
//          writes back the merged word.
// Assumes: a synchronous single-port memory with one cycle of read
//          latency; one command at a time (starts while busy are dropped).
module bptr_unit #(
    parameter int WORD_W = bptr_pkg::WORD_W_DEF,
    parameter int SZ_W   = bptr_pkg::SZ_W_DEF,
    parameter int POS_W  = bptr_pkg::POS_W_DEF,
    parameter int ADDR_W = bptr_pkg::ADDR_W_DEF,
    localparam int PTR_W = POS_W + SZ_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_deposit_i,
    input  logic              step_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [WORD_W-1:0] load_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);
    logic [PTR_W-1:0]  adv_ptr;
    logic [PTR_W-1:0]  ptr_q;
    logic [WORD_W-1:0] data_q;
    logic              dep_q;
    logic [WORD_W-1:0] load_q;
    logic [WORD_W-1:0] extract_w;
    logic [WORD_W-1:0] merge_w;
    logic              accept_w;
    logic              xfer_w;

    bptr_advance #(.WORD_W(WORD_W), .SZ_W(SZ_W), .POS_W(POS_W), .ADDR_W(ADDR_W)) adv_i (
        .en_i  (step_i),
        .ptr_i (ptr_i),
        .ptr_o (adv_ptr)
    );

    bptr_field #(.WORD_W(WORD_W), .SZ_W(SZ_W), .POS_W(POS_W)) fld_i (
        .word_i    (mem_rdata_i),
        .data_i    (data_q),
        .pos_i     (ptr_q[ADDR_W+SZ_W +: POS_W]),
        .size_i    (ptr_q[ADDR_W +: SZ_W]),
        .extract_o (extract_w),
        .merge_o   (merge_w)
    );

    bptr_ctrl ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .dep_i    (dep_q),
        .accept_o (accept_w),
        .xfer_o   (xfer_w),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .rd_o     (mem_rd_o),
        .wr_o     (mem_wr_o)
    );

    // Capture the command when accepted, and the load result on transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            data_q <= '0;
            dep_q  <= 1'b0;
            load_q <= '0;
        end else begin
            if (accept_w) begin
                ptr_q  <= adv_ptr;
                data_q <= data_i;
                dep_q  <= op_deposit_i;
            end
            if (xfer_w) load_q <= extract_w;
        end
    end

    assign ptr_o       = ptr_q;
    assign load_o      = load_q;
    assign mem_addr_o  = ptr_q[ADDR_W-1:0];
    assign mem_wdata_o = merge_w;

    assert_wr_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_addr_o == $past(mem_addr_o)));
    assert_ptr_stable_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ptr_o));
    assert_zero_width_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dep_q && (ptr_q[ADDR_W +: SZ_W] == '0)) |-> (load_o == '0));
endmodule

// File: tb/bptr_unit_tb.sv
// Scoreboard bench for bptr_unit: the driver pushes expected results,
// and a monitor compares them at each done pulse.
module bptr_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 64;

    typedef struct {
        logic        is_dep;
        logic [29:0] exp_ptr;
        logic [35:0] exp_load;
        logic [35:0] exp_word;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_deposit_i = 1'b0;
    logic        step_i = 1'b0;
    logic [29:0] ptr_i = '0;
    logic [35:0] data_i = '0;
    logic        busy_o, done_o, mem_rd_o, mem_wr_o;
    logic [29:0] ptr_o;
    logic [35:0] load_o, mem_wdata_o;
    logic [35:0] mem_rdata_i;
    logic [17:0] mem_addr_o;

    logic [35:0] mem     [MEM_N];
    logic [35:0] ref_mem [MEM_N];
    item_t       sb_q[$];
    int          errors = 0;
    int          checks = 0;
    int          dones  = 0;
    int          pushed = 0;
    logic        prev_rd = 1'b0;
    logic [17:0] prev_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bptr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_deposit_i(op_deposit_i),
        .step_i(step_i), .ptr_i(ptr_i), .data_i(data_i), .busy_o(busy_o),
        .done_o(done_o), .ptr_o(ptr_o), .load_o(load_o), .mem_addr_o(mem_addr_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i)
    );

    function automatic logic [35:0] init_word(int i);
        return 36'h9A5C3E71B ^ (36'(i) * 36'h0F1E2D3C5);
    endfunction

    // Synchronous memory model with one cycle of read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= init_word(i);
            mem_rdata_i <= '0;
        end else begin
            if (mem_wr_o) mem[mem_addr_o[5:0]] <= mem_wdata_o;
            if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[5:0]];
        end
    end

    function automatic logic [29:0] mk_ptr(int pos, int size, int addr);
        return {6'(pos), 6'(size), 18'(addr)};
    endfunction

    function automatic logic [29:0] model_step(logic [29:0] p, logic en);
        int pos, sz, ad;
        pos = int'(p[29:24]); sz = int'(p[23:18]); ad = int'(p[17:0]);
        if (!en) return p;
        if (pos >= sz) pos = pos - sz;
        else begin ad = ad + 1; pos = 36 - sz; end
        return mk_ptr(pos, sz, ad);
    endfunction

    function automatic logic [35:0] model_load(logic [35:0] w, int pos, int sz);
        logic [35:0] r = '0;
        for (int i = 0; i < 36; i++)
            if (i >= pos && i < pos + sz) r[i-pos] = w[i];
        return r;
    endfunction

    function automatic logic [35:0] model_dep(logic [35:0] w, logic [35:0] d, int pos, int sz);
        logic [35:0] r = w;
        for (int i = 0; i < 36; i++)
            if (i >= pos && i < pos + sz) r[i] = d[i-pos];
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: push the expected item, then pulse start and wait for done
    task automatic do_op(logic dep, logic stp, logic [29:0] p, logic [35:0] d,
                         string tag, output logic [29:0] nxt);
        item_t it;
        logic [29:0] ep;
        int a;
        while (busy_o) @(negedge clk);
        ep = model_step(p, stp);
        a  = int'(ep[5:0]);
        it.is_dep   = dep;
        it.exp_ptr  = ep;
        it.exp_load = model_load(ref_mem[a], int'(ep[29:24]), int'(ep[23:18]));
        it.exp_word = dep ? model_dep(ref_mem[a], d, int'(ep[29:24]), int'(ep[23:18]))
                          : ref_mem[a];
        it.tag = tag;
        ref_mem[a] = it.exp_word;
        sb_q.push_back(it);
        pushed++;
        op_deposit_i = dep; step_i = stp; ptr_i = p; data_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        @(negedge clk);
        nxt = ep;
    endtask

    // Monitor: compare at each done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            item_t it;
            dones++;
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected done", 36'(dones), 36'(pushed));
            end else begin
                it = sb_q.pop_front();
                check(ptr_o == it.exp_ptr, {it.tag, " ptr"}, 36'(ptr_o), 36'(it.exp_ptr));
                if (!it.is_dep)
                    check(load_o == it.exp_load, {it.tag, " load"}, load_o, it.exp_load);
                else
                    check(mem[it.exp_ptr[5:0]] == it.exp_word, {it.tag, " mem"},
                          mem[it.exp_ptr[5:0]], it.exp_word);
            end
        end
    end

    // R4 monitor: a write must directly follow a read of the same address
    always @(negedge clk) begin
        if (rst_n && mem_wr_o) begin
            check(prev_rd && !mem_rd_o, "R4 write not after read", 36'(prev_rd), 36'd1);
            check(mem_addr_o == prev_addr, "R4 write address", 36'(mem_addr_o), 36'(prev_addr));
        end
        prev_rd   = mem_rd_o;
        prev_addr = mem_addr_o;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [29:0] np;
        for (int i = 0; i < MEM_N; i++) ref_mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o, "R1 reset busy/done", {34'd0, busy_o, done_o}, 36'd0);
        check(!mem_rd_o && !mem_wr_o, "R1 reset mem strobes", {34'd0, mem_rd_o, mem_wr_o}, 36'd0);

        // R2 / R8 / R11 plain loads, no step
        do_op(1'b0, 1'b0, mk_ptr(30, 6, 1), '0, "R2 R8 load top byte", np);
        do_op(1'b0, 1'b0, mk_ptr(0, 36, 2), '0, "R2 full word", np);
        do_op(1'b0, 1'b0, mk_ptr(7, 11, 3), '0, "R2 odd field", np);
        // R3 zero width
        do_op(1'b0, 1'b0, mk_ptr(12, 0, 4), '0, "R3 zero width load", np);
        // R6 step inside the word
        do_op(1'b0, 1'b1, mk_ptr(10, 5, 5), '0, "R6 step in word", np);
        // R7 step crosses into the next word
        do_op(1'b0, 1'b1, mk_ptr(3, 6, 6), '0, "R7 step wraps", np);
        // R9 field clipped at the top of the word
        do_op(1'b0, 1'b0, mk_ptr(33, 6, 8), '0, "R9 clipped load", np);
        // R6 R7 chained stepping loads of 7-bit bytes across words
        np = mk_ptr(36, 7, 10);
        for (int k = 0; k < 7; k++) do_op(1'b0, 1'b1, np, '0, "R7 chain load", np);

        // R4 R5 deposits
        do_op(1'b1, 1'b0, mk_ptr(12, 8, 20), 36'hFFFFFFFA5, "R5 deposit byte", np);
        do_op(1'b1, 1'b0, mk_ptr(5, 0, 21), 36'hFFFFFFFFF, "R5 zero width deposit", np);
        do_op(1'b1, 1'b1, mk_ptr(2, 9, 22), 36'h000000155, "R7 deposit wrap", np);
        do_op(1'b1, 1'b0, mk_ptr(34, 6, 24), 36'h00000003F, "R9 clipped deposit", np);
        do_op(1'b0, 1'b0, mk_ptr(12, 8, 20), '0, "R5 read back deposit", np);
        np = mk_ptr(36, 12, 30);
        for (int k = 0; k < 4; k++) do_op(1'b1, 1'b1, np, 36'(k * 291 + 7), "R6 chain deposit", np);
        do_op(1'b0, 1'b0, mk_ptr(0, 36, 31), '0, "R6 chain read back", np);

        // R10 start while busy is dropped
        while (busy_o) @(negedge clk);
        begin
            item_t it;
            it.is_dep = 1'b0; it.exp_ptr = mk_ptr(4, 8, 40);
            it.exp_load = model_load(ref_mem[40], 4, 8);
            it.exp_word = ref_mem[40]; it.tag = "R10 first command";
            sb_q.push_back(it); pushed++;
        end
        op_deposit_i = 1'b0; step_i = 1'b0; ptr_i = mk_ptr(4, 8, 40); start_i = 1'b1;
        @(negedge clk);
        op_deposit_i = 1'b1; ptr_i = mk_ptr(0, 36, 41); data_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        check(dones == pushed, "R10 done count", 36'(dones), 36'(pushed));
        check(mem[41] == ref_mem[41], "R10 ignored deposit", mem[41], ref_mem[41]);
        check(!busy_o && sb_q.size() == 0, "R11 idle after done", 36'(sb_q.size()), 36'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule